// File: doc/BRIEF.md
# Windowed register index mapper

This block turns an architectural integer register number into a physical register file index for a core with overlapping register windows and banked global registers. It holds two small pieces of state: the window pointer, which selects the active window, and the global level, which selects the active bank of globals. Three independent lookup ports resolve a 5-bit architectural index against three views of that state. The current view uses the window pointer itself. The next view uses the pointer minus one and the previous view uses the pointer plus one, both wrapping around the window ring. All three views share the same global bank.

A fourth port maps a microcode scratch register number into a fixed region that sits above all globals and all windows. Software-visible writes to the window pointer and to the global level arrive on two write strobes. A window pointer value beyond the last window is clamped to the last window. Lookups are combinational from the held state, so each one answers in the cycle it is presented. A write becomes visible on the lookup ports in the cycle after the clock edge that takes it.

Top module: `win_reg_mapper`

## Requirements
- R1: Architectural index 0 maps to physical index 0 on every view, whatever the global level.
- R2: Architectural index a with 1 <= a <= 7 maps to a + 8*GL on all three views (8 globals per bank, 4 levels by default).
- R3: Architectural index a with 8 <= a <= 31 maps on the current view to 32 + ((a - 8 - 16*w) mod 128) with w = CWP (8 windows of 16 new registers, 32 globals in total).
- R4: The next view applies the R3 formula with w = CWP - 1 and the previous view with w = CWP + 1. The subtraction wraps, so at CWP = 0 the next view uses window 7. As a result, index 24+k (k in 0..7) on the previous view equals index 8+k on the current view.
- R5: A window pointer write with a value of 8 or more stores 7. A smaller value is stored unchanged.
- R6: Microcode scratch register k (0..7) maps to k + 160, which is above every global and windowed index.
- R7: While reset is held, and after it is released, CWP and GL are both 0.
- R8: A write to CWP or GL changes the lookups from the cycle after its clock edge. Without a write strobe, the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cwp_we | input | 1 | Window pointer write strobe |
| cwp_wdata | input | 8 | Window pointer write value (clamped) |
| gl_we | input | 1 | Global level write strobe |
| gl_wdata | input | 2 | Global level write value |
| cur_arch | input | 5 | Architectural index, current view |
| nxt_arch | input | 5 | Architectural index, next view |
| prv_arch | input | 5 | Architectural index, previous view |
| mic_idx | input | 3 | Microcode scratch register number |
| cur_phys | output | 8 | Physical index, current view |
| nxt_phys | output | 8 | Physical index, next view |
| prv_phys | output | 8 | Physical index, previous view |
| mic_phys | output | 8 | Physical index of the scratch register |

## Verification
The assertions assume that the write strobes and lookup indices are known (0 or 1) whenever reset is low. They also assume that the microcode number stays below the scratch register count. The bench drives every input from a defined value from time zero. It draws the microcode number only from 0..7 and lets the architectural indices range over all 32 codes. It also drives window pointer values up to 255 so that the clamp is exercised, while the global level input can only carry legal levels.

// File: rtl/win_map_pkg.sv
package win_map_pkg;
  // Views of the window ring served by the lookup ports.
  typedef enum logic [1:0] {
    VIEW_CUR = 2'd0,
    VIEW_NXT = 2'd1,
    VIEW_PRV = 2'd2
  } view_e;

  localparam int NUM_VIEWS = 3;
endpackage

// File: rtl/wmap_state.sv
module wmap_state #(
  parameter int NUM_WIN = 8,
  parameter int NUM_GL  = 4,
  parameter int WDATA_W = 8,
  localparam int CWP_W  = $clog2(NUM_WIN),
  localparam int GL_W   = $clog2(NUM_GL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cwp_we,
  input  logic [WDATA_W-1:0] cwp_wdata,
  input  logic               gl_we,
  input  logic [GL_W-1:0]    gl_wdata,
  output logic [CWP_W-1:0]   cwp_q,
  output logic [CWP_W-1:0]   cwp_dn_q,
  output logic [CWP_W-1:0]   cwp_up_q,
  output logic [GL_W-1:0]    gl_q
);
  localparam logic [WDATA_W-1:0] WIN_LIMIT = WDATA_W'(NUM_WIN);
  localparam logic [CWP_W-1:0]   LAST_WIN  = CWP_W'(NUM_WIN - 1);

  logic [CWP_W-1:0] cwp_sat;
  logic [CWP_W-1:0] cwp_dn_d;
  logic [CWP_W-1:0] cwp_up_d;

  // Clamp the written pointer, then precompute its neighbours so the
  // lookup path never carries the wrap logic.
  always_comb begin
    if (cwp_wdata >= WIN_LIMIT) cwp_sat = LAST_WIN;
    else                        cwp_sat = cwp_wdata[CWP_W-1:0];
    cwp_dn_d = (cwp_sat == '0)       ? LAST_WIN : cwp_sat - 1'b1;
    cwp_up_d = (cwp_sat == LAST_WIN) ? '0       : cwp_sat + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q    <= '0;
      cwp_dn_q <= LAST_WIN;
      cwp_up_q <= CWP_W'(1);
    end else if (cwp_we) begin
      cwp_q    <= cwp_sat;
      cwp_dn_q <= cwp_dn_d;
      cwp_up_q <= cwp_up_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        gl_q <= '0;
    else if (gl_we) gl_q <= gl_wdata;
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (cwp_q == '0 && gl_q == '0)); // R7

  AST_CWP_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (cwp_we && cwp_wdata >= WIN_LIMIT) |=> (cwp_q == LAST_WIN)); // R5

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cwp_we && !gl_we && !$past(rst)) |=> ($stable(cwp_q) && $stable(gl_q))); // R8
endmodule

// File: rtl/wmap_port.sv
module wmap_port #(
  parameter int NUM_WIN      = 8,
  parameter int WIN_REGS     = 16,
  parameter int GLB_PER_BANK = 8,
  parameter int NUM_GL       = 4,
  parameter int NUM_MICRO    = 8,
  parameter int ARCH_W       = 5,
  localparam int CWP_W   = $clog2(NUM_WIN),
  localparam int GL_W    = $clog2(NUM_GL),
  localparam int TOT_GLB = NUM_GL * GLB_PER_BANK,
  localparam int TOT_WIN = NUM_WIN * WIN_REGS,
  localparam int PHYS_W  = $clog2(TOT_GLB + TOT_WIN + NUM_MICRO),
  localparam int SUM_W   = $clog2(2 * TOT_WIN) + 1
) (
  input  logic [ARCH_W-1:0] arch_idx,
  input  logic [CWP_W-1:0]  win_ptr,
  input  logic [GL_W-1:0]   gl,
  output logic [PHYS_W-1:0] phys_idx
);
  localparam logic [ARCH_W-1:0] FIRST_WIN = ARCH_W'(GLB_PER_BANK);
  localparam logic [SUM_W-1:0]  RING      = SUM_W'(TOT_WIN);
  localparam logic [SUM_W-1:0]  STRIDE    = SUM_W'(WIN_REGS);
  localparam logic [PHYS_W-1:0] WIN_BASE  = PHYS_W'(TOT_GLB);
  localparam logic [PHYS_W-1:0] BANK_SZ   = PHYS_W'(GLB_PER_BANK);

  logic              is_glb;
  logic [PHYS_W-1:0] glb_phys;
  logic [SUM_W-1:0]  win_off;
  logic [SUM_W-1:0]  rot;
  logic [SUM_W-1:0]  ring_sum;
  logic [SUM_W-1:0]  ring_pos;

  assign is_glb = (arch_idx < FIRST_WIN);

  // Global bank: index 0 is the hardwired zero, the rest shift by level.
  always_comb begin
    if (arch_idx == '0) glb_phys = '0;
    else glb_phys = PHYS_W'(arch_idx) + PHYS_W'(gl) * BANK_SZ;
  end

  // Windowed: rotate by the pointer inside a ring of TOT_WIN entries.
  // Adding the ring size first keeps the intermediate non-negative.
  always_comb begin
    win_off  = SUM_W'(arch_idx - FIRST_WIN);
    rot      = SUM_W'(win_ptr) * STRIDE;
    ring_sum = win_off + RING - rot;
    ring_pos = (ring_sum >= RING) ? ring_sum - RING : ring_sum;
  end

  assign phys_idx = is_glb ? glb_phys : WIN_BASE + PHYS_W'(ring_pos);
endmodule

// File: rtl/wmap_micro.sv
module wmap_micro #(
  parameter int NUM_WIN      = 8,
  parameter int WIN_REGS     = 16,
  parameter int GLB_PER_BANK = 8,
  parameter int NUM_GL       = 4,
  parameter int NUM_MICRO    = 8,
  localparam int MIC_W   = $clog2(NUM_MICRO),
  localparam int PHYS_W  = $clog2(NUM_GL * GLB_PER_BANK + NUM_WIN * WIN_REGS + NUM_MICRO)
) (
  input  logic [MIC_W-1:0]  mic_idx,
  output logic [PHYS_W-1:0] mic_phys
);
  localparam logic [PHYS_W-1:0] MIC_BASE =
    PHYS_W'(NUM_GL * GLB_PER_BANK + NUM_WIN * WIN_REGS);

  assign mic_phys = MIC_BASE + PHYS_W'(mic_idx);
endmodule

// File: rtl/win_reg_mapper.sv
module win_reg_mapper #(
  parameter int NUM_WIN      = 8,
  parameter int WIN_REGS     = 16,
  parameter int GLB_PER_BANK = 8,
  parameter int NUM_GL       = 4,
  parameter int NUM_MICRO    = 8,
  parameter int ARCH_W       = 5,
  parameter int WDATA_W      = 8,
  localparam int CWP_W   = $clog2(NUM_WIN),
  localparam int GL_W    = $clog2(NUM_GL),
  localparam int MIC_W   = $clog2(NUM_MICRO),
  localparam int TOT_GLB = NUM_GL * GLB_PER_BANK,
  localparam int TOT_WIN = NUM_WIN * WIN_REGS,
  localparam int PHYS_W  = $clog2(TOT_GLB + TOT_WIN + NUM_MICRO)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cwp_we,
  input  logic [WDATA_W-1:0] cwp_wdata,
  input  logic               gl_we,
  input  logic [GL_W-1:0]    gl_wdata,
  input  logic [ARCH_W-1:0]  cur_arch,
  input  logic [ARCH_W-1:0]  nxt_arch,
  input  logic [ARCH_W-1:0]  prv_arch,
  input  logic [MIC_W-1:0]   mic_idx,
  output logic [PHYS_W-1:0]  cur_phys,
  output logic [PHYS_W-1:0]  nxt_phys,
  output logic [PHYS_W-1:0]  prv_phys,
  output logic [PHYS_W-1:0]  mic_phys
);
  import win_map_pkg::*;

  logic [CWP_W-1:0]  cwp_q, cwp_dn_q, cwp_up_q;
  logic [GL_W-1:0]   gl_q;
  logic [ARCH_W-1:0] arch_v [NUM_VIEWS];
  logic [PHYS_W-1:0] phys_v [NUM_VIEWS];

  wmap_state #(
    .NUM_WIN(NUM_WIN), .NUM_GL(NUM_GL), .WDATA_W(WDATA_W)
  ) u_state (
    .clk(clk), .rst(rst),
    .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
    .gl_we(gl_we), .gl_wdata(gl_wdata),
    .cwp_q(cwp_q), .cwp_dn_q(cwp_dn_q), .cwp_up_q(cwp_up_q), .gl_q(gl_q)
  );

  assign arch_v[VIEW_CUR] = cur_arch;
  assign arch_v[VIEW_NXT] = nxt_arch;
  assign arch_v[VIEW_PRV] = prv_arch;

  for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_view
    logic [CWP_W-1:0] ptr;
    if (v == int'(VIEW_CUR)) begin : g_cur
      assign ptr = cwp_q;
    end else if (v == int'(VIEW_NXT)) begin : g_nxt
      assign ptr = cwp_dn_q;
    end else begin : g_prv
      assign ptr = cwp_up_q;
    end
    wmap_port #(
      .NUM_WIN(NUM_WIN), .WIN_REGS(WIN_REGS), .GLB_PER_BANK(GLB_PER_BANK),
      .NUM_GL(NUM_GL), .NUM_MICRO(NUM_MICRO), .ARCH_W(ARCH_W)
    ) u_port (
      .arch_idx(arch_v[v]), .win_ptr(ptr), .gl(gl_q), .phys_idx(phys_v[v])
    );
  end

  assign cur_phys = phys_v[VIEW_CUR];
  assign nxt_phys = phys_v[VIEW_NXT];
  assign prv_phys = phys_v[VIEW_PRV];

  wmap_micro #(
    .NUM_WIN(NUM_WIN), .WIN_REGS(WIN_REGS), .GLB_PER_BANK(GLB_PER_BANK),
    .NUM_GL(NUM_GL), .NUM_MICRO(NUM_MICRO)
  ) u_micro (
    .mic_idx(mic_idx), .mic_phys(mic_phys)
  );

  localparam logic [ARCH_W-1:0] FIRST_WIN = ARCH_W'(GLB_PER_BANK);
  localparam logic [ARCH_W-1:0] OVL_SHIFT = ARCH_W'(WIN_REGS);
  localparam logic [PHYS_W-1:0] WIN_LO    = PHYS_W'(TOT_GLB);
  localparam logic [PHYS_W-1:0] MIC_LO    = PHYS_W'(TOT_GLB + TOT_WIN);

  AST_ZERO_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    (cur_arch == '0 || nxt_arch == '0) |->
      ((cur_arch != '0 || cur_phys == '0) && (nxt_arch != '0 || nxt_phys == '0))); // R1

  AST_SHARED_BANK: assert property (@(posedge clk) disable iff (rst)
    (cur_arch == nxt_arch && cur_arch < FIRST_WIN) |-> (cur_phys == nxt_phys)); // R2

  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cur_arch >= FIRST_WIN) |-> (cur_phys >= WIN_LO && cur_phys < MIC_LO)); // R3

  AST_WIN_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    (cur_arch >= FIRST_WIN && cur_arch < FIRST_WIN + FIRST_WIN &&
     prv_arch == cur_arch + OVL_SHIFT) |-> (prv_phys == cur_phys)); // R4

  AST_MICRO_ABOVE: assert property (@(posedge clk) disable iff (rst)
    (mic_phys >= MIC_LO)); // R6
endmodule

// File: tb/tb_win_reg_mapper.sv
`timescale 1ns/1ps
module tb_win_reg_mapper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cwp_we = 1'b0;
  logic [7:0] cwp_wdata = '0;
  logic       gl_we = 1'b0;
  logic [1:0] gl_wdata = '0;
  logic [4:0] cur_arch = '0, nxt_arch = '0, prv_arch = '0;
  logic [2:0] mic_idx = '0;
  logic [7:0] cur_phys, nxt_phys, prv_phys, mic_phys;

  int n_checks = 0;
  int n_fail   = 0;
  int m_cwp    = 0;
  int m_gl     = 0;
  bit started  = 1'b0;
  bit done     = 1'b0;
  string tag_force = "";

  always #2.5 clk = ~clk;

  win_reg_mapper dut (
    .clk(clk), .rst(rst), .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
    .gl_we(gl_we), .gl_wdata(gl_wdata),
    .cur_arch(cur_arch), .nxt_arch(nxt_arch), .prv_arch(prv_arch),
    .mic_idx(mic_idx), .cur_phys(cur_phys), .nxt_phys(nxt_phys),
    .prv_phys(prv_phys), .mic_phys(mic_phys)
  );

  // Behavioural reference: 8 windows x 16, 4 banks x 8 globals.
  function automatic int exp_map(int a, int w, int g);
    if (a == 0) return 0;
    if (a < 8)  return a + g * 8;
    return 32 + (((a - 8) - 16 * w + 2048) % 128);
  endfunction

  function automatic string tag_of(int a, bit side_view);
    if (a == 0) return "R1";
    if (a < 8)  return "R2";
    return side_view ? "R4" : "R3";
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cwp %0d gl %0d)",
               tag, what, act, exp, m_cwp, m_gl);
    end
  endtask

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      m_cwp = 0;
      m_gl  = 0;
    end else begin
      if (cwp_we) m_cwp = (int'(cwp_wdata) >= 8) ? 7 : int'(cwp_wdata);
      if (gl_we)  m_gl  = int'(gl_wdata);
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      string t;
      t = rst ? "R7" : tag_force;
      check(t != "" ? t : tag_of(cur_arch, 1'b0), cur_phys,
            exp_map(cur_arch, m_cwp, m_gl), "cur");
      check(t != "" ? t : tag_of(nxt_arch, 1'b1), nxt_phys,
            exp_map(nxt_arch, m_cwp - 1, m_gl), "nxt");
      check(t != "" ? t : tag_of(prv_arch, 1'b1), prv_phys,
            exp_map(prv_arch, m_cwp + 1, m_gl), "prv");
      check(rst ? "R7" : "R6", mic_phys, 160 + int'(mic_idx), "mic");
    end
  end

  task automatic drive(bit cwe, int cval, bit gwe, int gval,
                       int ca, int na, int pa, int mi, string tag);
    @(posedge clk);
    #1;
    cwp_we = cwe; cwp_wdata = 8'(cval);
    gl_we  = gwe; gl_wdata  = 2'(gval);
    cur_arch = 5'(ca); nxt_arch = 5'(na); prv_arch = 5'(pa);
    mic_idx = 3'(mi);
    tag_force = tag;
  endtask

  initial begin
    // R7: reset state, lookups at CWP 0 / GL 0 (index 8 -> 32, nxt -> 48).
    drive(0, 0, 0, 0, 8, 8, 8, 0, "");
    drive(0, 0, 0, 0, 5, 0, 31, 7, "");
    drive(0, 0, 0, 0, 8, 8, 8, 3, "");
    #1 rst = 1'b0;
    drive(0, 0, 0, 0, 8, 8, 24, 1, "R7");
    // R4: wrap at CWP 0: next view uses window 7, previous window 1.
    drive(0, 0, 0, 0, 8, 31, 8, 2, "R4");
    // R5: clamp of 13 and 255, then a legal value; R8 visible next cycle.
    drive(1, 13, 0, 0, 8, 8, 8, 0, "R8");
    drive(0, 0, 0, 0, 8, 8, 15, 0, "R5");
    drive(1, 255, 0, 0, 20, 20, 20, 0, "R5");
    drive(1, 3, 0, 0, 8, 8, 8, 0, "R5");
    drive(0, 0, 0, 0, 9, 9, 25, 0, "R5");
    // R8: GL write changes the bank from the next cycle; index 0 stays 0.
    drive(0, 0, 1, 3, 5, 5, 0, 0, "R8");
    drive(0, 0, 0, 0, 5, 5, 0, 0, "R8");
    drive(0, 0, 0, 2, 7, 0, 1, 0, "R8");
    drive(1, 7, 1, 1, 31, 31, 31, 0, "R8");
    drive(0, 0, 0, 0, 8, 8, 8, 0, "R4");
    // Random stream over all indices, clamp values and levels.
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 16);
      drive(r == 0, (r == 1) ? 200 : int'($urandom % 16), r == 2,
            int'($urandom % 4), int'($urandom % 32), int'($urandom % 32),
            int'($urandom % 32), int'($urandom % 8), "");
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, "");
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    done = 1'b1;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule